// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block is a master-side helper for a two-wire serial bus. It frees a slave that was left in the middle of a transfer when the host was reset. A typical case is a memory device that keeps SDA low because it is sending a zero data bit or an acknowledge. When asked, the sequencer leaves SDA released and runs nine full SCL clock pulses, which walks the slave out of whatever byte it was in. Straight after the ninth pulse it places a start condition on the bus and then a stop condition, so the slave resets its protocol logic and returns to standby. It then raises a one-cycle completion pulse.

Both bus lines are open-drain. The block drives only active-high pull-down enables, and it watches the resolved line levels through `scl_in` and `sda_in`, which it synchronises to the system clock. Every SCL phase and every setup or hold interval lasts `HALF_CLKS` system clocks. An interval in which SCL is released is timed only while the synchronised line actually reads high, so a slave that stretches the clock makes the sequence longer. At the end of the ninth high phase the block samples SDA. If SDA is still low it sets `sda_stuck`, but the start and stop are still generated. The request and completion pins are plain level and pulse controls, since no data moves through the block.

Top module: `busrec_seq`

## Requirements
- R1: While reset is asserted and after it is released, both pull-down enables are low (both lines released) and `busy`, `done` and `sda_stuck` are all low.
- R2: `req` high in a cycle where the block is idle starts a sequence. The first bus action is SCL driven low, and SDA is not driven at any point during the clocking part. Whenever `busy` is low, both enables are low.
- R3: Exactly `NUM_PULSES` (9) rising edges appear on the SCL line before the block first drives SDA low.
- R4: Every interval with SCL driven low lasts exactly `HALF_CLKS` system clocks.
- R5: When SDA is free, the bus carries exactly one start and then one stop after the dummy clocks. The stop follows the start by 3*`HALF_CLKS` + `SYNC_STAGES` cycles: SDA is held low with SCL high, then SCL is driven low, then SCL is released, then SDA is released.
- R6: `sda_oe` changes while SCL is released (and was released one cycle earlier) exactly twice per sequence: once rising for the start and once falling for the stop.
- R7: `done` is high for exactly one cycle per sequence, in the last cycle of `busy`. Without stretching, `busy` lasts 22*`HALF_CLKS` + 10*`SYNC_STAGES` + 1 cycles. Each cycle in which a slave holds SCL low during a released-SCL interval adds one cycle.
- R8: `sda_stuck` equals the inverse of the synchronised SDA level at the end of the ninth high phase. It does not stop the sequence, it holds its value until the next accepted request, and that request clears it.
- R9: `req` is ignored while a sequence is running. Neither the length of the sequence nor the number of `done` pulses changes, and the block is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start a recovery sequence when idle |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| busy | output | 1 | Sequence in progress, including the completion cycle |
| done | output | 1 | One-cycle completion pulse |
| sda_stuck | output | 1 | SDA was still low after the dummy clocks |

## Verification
The assertions assume that `req` is a synchronous level. They also assume that any slave holds SCL low only for a bounded time after release, so the released-SCL intervals always end. The stimulus drives `req`, the clock stretch and the slave SDA hold only at falling clock edges. It stretches only during one of the nine high phases, by one to five cycles. The simulated slave lets go of SDA only on an SCL falling edge, or keeps it low until `done` when it plays a stuck part.

// File: rtl/busrec_pkg.sv
package busrec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE        = 3'd0,
    ST_CLK_LOW     = 3'd1,
    ST_CLK_HIGH    = 3'd2,
    ST_START_SETUP = 3'd3,
    ST_START       = 3'd4,
    ST_STOP_SETUP  = 3'd5,
    ST_STOP        = 3'd6,
    ST_DONE        = 3'd7
  } rec_state_t;

  function automatic logic scl_pulled(rec_state_t s);
    return (s == ST_CLK_LOW) || (s == ST_STOP_SETUP);
  endfunction

  function automatic logic sda_pulled(rec_state_t s);
    return (s == ST_START) || (s == ST_STOP_SETUP) || (s == ST_STOP);
  endfunction

  function automatic logic scl_released_timed(rec_state_t s);
    return (s == ST_CLK_HIGH) || (s == ST_START_SETUP) ||
           (s == ST_START) || (s == ST_STOP);
  endfunction
endpackage

// File: rtl/busrec_sync.sv
module busrec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else if (STAGES == 1) chain_q <= d;
        else chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/busrec_phase_timer.sv
module busrec_phase_timer #(
  parameter int HALF_CLKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic count_en,
  output logic expire
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire = count_en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart)   cnt_q <= '0;
    else if (count_en)  cnt_q <= cnt_q + 1'b1;
  end

  // R4
  tmr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= LAST));
  // R4
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && count_en && !expire) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/busrec_pulse_ctr.sv
module busrec_pulse_ctr #(
  parameter int NUM_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int PW = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;
  localparam logic [PW-1:0] TOP = PW'(NUM_PULSES - 1);

  logic [PW-1:0] cnt_q;

  assign last = (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear)            cnt_q <= '0;
    else if (step && !last)    cnt_q <= cnt_q + 1'b1;
  end

  // R3
  pulse_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= TOP));
  // R3
  pulse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |-> !last);
endmodule

// File: rtl/busrec_line_ctl.sv
module busrec_line_ctl
  import busrec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rec_state_t state_d,
  output logic       scl_oe,
  output logic       sda_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_oe <= scl_pulled(state_d);
      sda_oe <= sda_pulled(state_d);
    end
  end

  // R6
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!scl_oe && !$past(scl_oe)));
  // R5
  stop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) && sda_oe |=> sda_oe);
endmodule

// File: rtl/busrec_seq.sv
module busrec_seq
  import busrec_pkg::*;
#(
  parameter int HALF_CLKS   = 250,
  parameter int NUM_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic sda_stuck
);
  rec_state_t state_q, state_d;
  logic scl_s, sda_s;
  logic tmr_restart, tmr_en, tmr_exp;
  logic pc_clear, pc_step, pc_last;
  logic stuck_load;

  busrec_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
  busrec_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

  busrec_phase_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart),
    .count_en(tmr_en), .expire(tmr_exp));

  busrec_pulse_ctr #(.NUM_PULSES(NUM_PULSES)) u_pulses (
    .clk(clk), .rst_n(rst_n), .clear(pc_clear),
    .step(pc_step), .last(pc_last));

  busrec_line_ctl u_lines (
    .clk(clk), .rst_n(rst_n), .state_d(state_d),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  always_comb begin
    if (scl_released_timed(state_q)) tmr_en = scl_s;
    else                              tmr_en = (state_q == ST_CLK_LOW) ||
                                               (state_q == ST_STOP_SETUP);
  end

  always_comb begin
    state_d     = state_q;
    tmr_restart = 1'b0;
    pc_clear    = 1'b0;
    pc_step     = 1'b0;
    stuck_load  = 1'b0;
    case (state_q)
      ST_IDLE: if (req) begin
        state_d     = ST_CLK_LOW;
        tmr_restart = 1'b1;
        pc_clear    = 1'b1;
      end
      ST_CLK_LOW: if (tmr_exp) begin
        state_d     = ST_CLK_HIGH;
        tmr_restart = 1'b1;
      end
      ST_CLK_HIGH: if (tmr_exp) begin
        tmr_restart = 1'b1;
        if (pc_last) begin
          state_d    = ST_START_SETUP;
          stuck_load = 1'b1;
        end else begin
          state_d = ST_CLK_LOW;
          pc_step = 1'b1;
        end
      end
      ST_START_SETUP: if (tmr_exp) begin
        state_d     = ST_START;
        tmr_restart = 1'b1;
      end
      ST_START: if (tmr_exp) begin
        state_d     = ST_STOP_SETUP;
        tmr_restart = 1'b1;
      end
      ST_STOP_SETUP: if (tmr_exp) begin
        state_d     = ST_STOP;
        tmr_restart = 1'b1;
      end
      ST_STOP: if (tmr_exp) begin
        state_d     = ST_DONE;
        tmr_restart = 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sda_stuck <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pc_clear)        sda_stuck <= 1'b0;
      else if (stuck_load) sda_stuck <= ~sda_s;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_DONE);

  // R7
  done_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R2
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));
  // R8
  stuck_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(sda_stuck));
  // R9
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && state_q != ST_CLK_LOW) |=> (state_q != ST_CLK_LOW) || $past(state_q == ST_CLK_HIGH));
endmodule

// File: tb/sim_busrec_seq.sv
module sim_busrec_seq;
  localparam int HALF = 4;
  localparam int SYNC = 2;
  localparam int NP   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic stretch = 1'b0;
  logic hold = 1'b0;
  logic scl_oe, sda_oe, busy, done, sda_stuck;
  wire  scl_line = !scl_oe && !stretch;
  wire  sda_line = !sda_oe && !hold;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  busrec_seq #(.HALF_CLKS(HALF), .NUM_PULSES(NP), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .sda_stuck(sda_stuck));

  int cfg_hold_n, cfg_st_k, cfg_st_s;
  int arm_seq = 0, arm_seen = 0;
  int m_busy, m_done, m_rise, m_lowbad, m_lowrun, m_start, m_stop;
  int m_start_t, m_stop_t, m_sdachg, m_rel, m_falls, st_left;
  bit m_sda_seen;
  logic p_scl_oe = 1'b0, p_sda_oe = 1'b0, p_scl = 1'b1, p_sda = 1'b1;

  always @(negedge clk) begin
    if (arm_seq != arm_seen) begin
      arm_seen = arm_seq;
      m_busy = 0; m_done = 0; m_rise = 0; m_lowbad = 0; m_lowrun = 0;
      m_start = 0; m_stop = 0; m_start_t = 0; m_stop_t = 0; m_sdachg = 0;
      m_rel = 0; m_falls = 0; st_left = 0; m_sda_seen = 0;
      stretch = 1'b0;
      hold = (cfg_hold_n > 0);
    end else begin
      if (busy) m_busy++;
      if (done) m_done++;
      if (scl_line && !p_scl && !m_sda_seen) m_rise++;
      if (sda_oe && !p_sda_oe) m_sda_seen = 1;
      if (scl_oe) m_lowrun++;
      else if (p_scl_oe) begin
        if (m_lowrun != HALF) m_lowbad++;
        m_lowrun = 0;
      end
      if (sda_oe != p_sda_oe && !scl_oe && !p_scl_oe) m_sdachg++;
      if (busy && p_scl && scl_line && p_sda && !sda_line) begin m_start++; m_start_t = m_busy; end
      if (busy && p_scl && scl_line && !p_sda && sda_line) begin m_stop++; m_stop_t = m_busy; end
      if (!scl_line && p_scl) begin
        m_falls++;
        if (m_falls == cfg_hold_n) hold = 1'b0;
      end
      if (done) hold = 1'b0;
      if (!scl_oe && p_scl_oe) begin
        m_rel++;
        if (m_rel == cfg_st_k && cfg_st_s > 0) begin stretch = 1'b1; st_left = cfg_st_s - 1; end
      end else if (stretch) begin
        if (st_left == 0) stretch = 1'b0;
        else st_left--;
      end
    end
    p_scl_oe = scl_oe;
    p_sda_oe = sda_oe;
    p_scl = !scl_oe && !stretch;
    p_sda = !sda_oe && !hold;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int exp_len(input int k, input int s);
    return 22*HALF + 10*SYNC + 1 + ((k >= 1 && k <= NP) ? s : 0);
  endfunction

  task automatic run(input int hold_n, input int st_k, input int st_s, input int extra_at);
    int c;
    bit stuck_exp;
    @(negedge clk);
    cfg_hold_n = hold_n; cfg_st_k = st_k; cfg_st_s = st_s;
    arm_seq++;
    repeat (2) @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    c = 0;
    while (busy) begin
      @(negedge clk);
      c++;
      req = (c == extra_at) && busy;
    end
    req = 1'b0;
    stuck_exp = (hold_n > NP);
    repeat (4) begin
      @(negedge clk);
      chk(!busy, "R9 idle after sequence", busy, 0);
    end
    chk(m_busy == exp_len(st_k, st_s), "R7 busy length", m_busy, exp_len(st_k, st_s));
    chk(m_done == 1, "R7 done pulses", m_done, 1);
    chk(m_rise == NP, "R3 SCL rises before start", m_rise, NP);
    chk(m_lowbad == 0, "R4 low phase width", m_lowbad, 0);
    chk(m_sdachg == 2, "R6 SDA changes with SCL released", m_sdachg, 2);
    chk(sda_stuck == stuck_exp, "R8 stuck flag", sda_stuck, stuck_exp);
    chk(!scl_oe && !sda_oe, "R2 lines released when idle", {scl_oe, sda_oe}, 0);
    if (!stuck_exp) begin
      chk(m_start == 1 && m_stop == 1, "R5 start and stop count", m_start*10 + m_stop, 11);
      chk(m_stop_t - m_start_t == 3*HALF + SYNC, "R5 start to stop spacing",
          m_stop_t - m_start_t, 3*HALF + SYNC);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done && !sda_stuck, "R1 in reset",
        {scl_oe, sda_oe, busy, done, sda_stuck}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done && !sda_stuck, "R1 after reset",
        {scl_oe, sda_oe, busy, done, sda_stuck}, 0);
    // R2 R3 R4 R5: free bus
    run(0, 0, 0, 0);
    // R8: slave never lets go
    run(99, 0, 0, 0);
    // R8: flag cleared by next request, boundary release on ninth fall
    run(NP, 0, 0, 0);
    // R7: stretch on last high phase
    run(3, NP, 5, 0);
    // R9: request during sequence
    run(0, 0, 0, 40);
    run(0, 2, 3, 1);
    for (int i = 0; i < 20; i++) begin
      int h, k, s, e;
      h = $urandom % 12;
      if (h > NP) h = 99;
      k = $urandom % 10;
      s = 1 + ($urandom % 5);
      e = (($urandom % 3) == 0) ? 1 + ($urandom % 100) : 0;
      run(h, k, s, e);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule